// File: doc/BRIEF.md
# Forwarded Coherence Request Dispatcher

This block sits beside one line of a private first-level cache and decides what the line does with each coherence message that arrives on the forward queue. It classifies the message into an event, looks at the line's current stable or transient state, and returns three things. The first is the queue action: consume the message, or put it back for a later retry. The second is an optional data reply, plain or exclusive, sourced either from the cache array or from the eviction buffer. The third is the state the line should take next.

Reads issued on behalf of a DMA engine form their own event. They collect data from any line that holds it and never demote the line. Processor exclusive reads and DMA writes share the ownership-transfer path. Tag lookup, the data array, the eviction buffer and the network are outside the block and appear only as ports.

One message is handled per cycle. The forward queue is accepted only while the reply channel is ready. Queue and state outputs are combinational in the accepting cycle. The reply is registered and holds while the reply channel stalls.

Top module: `fwd_dispatcher`

## Requirements
- R1: Message type codes are 0 exclusive read, 1 shared read, 2 DMA read, 3 DMA write, 4 invalidate, 5 writeback done (6 and 7 unused). Requestor kind codes are 0 first-level cache, 1 second-level cache, 2 directory, 3 DMA. Types 0 and 3 form the self-exclusive event only when the requestor ID equals `myId` and the kind is 0; otherwise they form the foreign-exclusive event. The self-exclusive event outside the hold states is consumed with no reply and no state change.
- R2: State codes are 0 INVALID, 1 SHARED, 2 OWNED, 3 MODIFIED, 4 MODX (exclusive dirty), 5 SHR_UP, 6 OWN_UP, 7 INV_UP, 8 MOD_HOLD, 9 MODX_HOLD, 10 MOD_EVICT, 11 SHR_EVICT, 12 OWN_EVICT, 13 DROPPED. In MODIFIED or MODX, a DMA read returns plain array data and keeps the state. A shared read returns plain array data and moves the line to OWNED.
- R3: In SHARED, OWNED, SHR_UP and OWN_UP, shared reads and DMA reads are treated alike. Each returns plain array data, is consumed, and leaves the state unchanged.
- R4: In MOD_HOLD and MODX_HOLD, the following are recycled: shared read, DMA read, foreign-exclusive, self-exclusive and invalidate. A recycled message raises the recycle strobe without pop, sends no reply and writes no state.
- R5: In MOD_EVICT, each forwarded request is answered from the eviction buffer. A DMA read returns plain data and stays in MOD_EVICT. A foreign-exclusive request returns exclusive data and moves to DROPPED. A shared read returns plain data and moves to OWN_EVICT.
- R6: In SHR_EVICT and OWN_EVICT, shared reads and DMA reads return plain eviction-buffer data with no state change. In OWN_EVICT, a foreign-exclusive request returns exclusive buffer data and moves to DROPPED.
- R7: A foreign-exclusive request in MODIFIED, MODX or OWNED returns exclusive array data and moves to INVALID. In OWN_UP it returns exclusive array data and moves to INV_UP.
- R8: An invalidate moves SHARED to INVALID and SHR_UP to INV_UP, consumed with no reply.
- R9: Writeback done moves MOD_EVICT, SHR_EVICT, OWN_EVICT and DROPPED to INVALID. In every other state, including the hold states, it is consumed with no state change.
- R10: Every combination not listed above, including type codes 6 and 7, is consumed with no reply and `nextState` equal to `lineState`.
- R11: `reqReady` follows `respReady`. On an accepted message exactly one of pop and recycle is high in the same cycle, and `stateWe` equals pop. A reply is valid from the cycle after acceptance, carrying the requestor ID and address. The reply holds unchanged while `respReady` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| myId | input | ID_W | This cache's node ID |
| reqValid | input | 1 | Forward-queue message present |
| reqReady | output | 1 | Message accepted this cycle when high with reqValid |
| reqType | input | 3 | Message type code |
| reqId | input | ID_W | Requestor node ID |
| reqMachine | input | 2 | Requestor kind code |
| reqAddr | input | ADDR_W | Line address |
| lineState | input | 4 | Current line state code |
| arrayData | input | DATA_W | Line data from the cache array |
| wbData | input | DATA_W | Line data from the eviction buffer |
| respReady | input | 1 | Reply channel can take a reply |
| respValid | output | 1 | Reply present |
| respExcl | output | 1 | Reply grants exclusive data |
| respFromWb | output | 1 | Reply data came from the eviction buffer |
| respDest | output | ID_W | Reply destination (the requestor) |
| respAddr | output | ADDR_W | Reply address |
| respData | output | DATA_W | Reply data |
| popFwd | output | 1 | Consume the message |
| recycleReq | output | 1 | Re-enqueue the unchanged message |
| stateWe | output | 1 | Write nextState into the line |
| nextState | output | 4 | State for the line |

## Verification
Pop, recycle, state write and `reqReady` are combinational. They are due in the same cycle the message is driven. The bench drives inputs on the falling edge and samples these outputs a short delay later, before the accepting rising edge. The registered reply is due one rising edge after acceptance, so the bench samples it shortly after that edge. To check the stall rule, the bench lowers `respReady` for a cycle and confirms that the previous reply survives the edge unchanged and that nothing is consumed.

// File: rtl/fwd_disp_pkg.sv
package fwd_disp_pkg;

  localparam logic [2:0] MSG_RD_EXCL   = 3'd0;
  localparam logic [2:0] MSG_RD_SHARED = 3'd1;
  localparam logic [2:0] MSG_DMA_RD    = 3'd2;
  localparam logic [2:0] MSG_DMA_WR    = 3'd3;
  localparam logic [2:0] MSG_INVAL     = 3'd4;
  localparam logic [2:0] MSG_WB_DONE   = 3'd5;

  localparam logic [1:0] KIND_L1 = 2'd0;

  localparam int ST_W = 4;
  localparam logic [ST_W-1:0] ST_INVALID   = 4'd0;
  localparam logic [ST_W-1:0] ST_SHARED    = 4'd1;
  localparam logic [ST_W-1:0] ST_OWNED     = 4'd2;
  localparam logic [ST_W-1:0] ST_MODIFIED  = 4'd3;
  localparam logic [ST_W-1:0] ST_MODX      = 4'd4;
  localparam logic [ST_W-1:0] ST_SHR_UP    = 4'd5;
  localparam logic [ST_W-1:0] ST_OWN_UP    = 4'd6;
  localparam logic [ST_W-1:0] ST_INV_UP    = 4'd7;
  localparam logic [ST_W-1:0] ST_MOD_HOLD  = 4'd8;
  localparam logic [ST_W-1:0] ST_MODX_HOLD = 4'd9;
  localparam logic [ST_W-1:0] ST_MOD_EVICT = 4'd10;
  localparam logic [ST_W-1:0] ST_SHR_EVICT = 4'd11;
  localparam logic [ST_W-1:0] ST_OWN_EVICT = 4'd12;
  localparam logic [ST_W-1:0] ST_DROPPED   = 4'd13;

  typedef enum logic [2:0] {
    EV_OWN_EXCL   = 3'd0,
    EV_FWD_EXCL   = 3'd1,
    EV_FWD_SHARED = 3'd2,
    EV_FWD_DMA    = 3'd3,
    EV_INVAL      = 3'd4,
    EV_WB_DONE    = 3'd5,
    EV_OTHER      = 3'd6
  } fwdEv_e;

  typedef struct packed {
    logic send;
    logic excl;
    logic fromWb;
    logic pop;
    logic requeue;
    logic stWe;
  } ctrlStb_t;

endpackage

// File: rtl/fwd_event_classify.sv
module fwd_event_classify
  import fwd_disp_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic [2:0]      reqType,
  input  logic [ID_W-1:0] reqId,
  input  logic [1:0]      reqMachine,
  input  logic [ID_W-1:0] myId,
  output fwdEv_e          ev
);

  logic isSelf;
  assign isSelf = (reqId == myId) && (reqMachine == KIND_L1);

  always_comb begin
    case (reqType)
      MSG_RD_EXCL, MSG_DMA_WR: ev = isSelf ? EV_OWN_EXCL : EV_FWD_EXCL;
      MSG_RD_SHARED:           ev = EV_FWD_SHARED;
      MSG_DMA_RD:              ev = EV_FWD_DMA;
      MSG_INVAL:               ev = EV_INVAL;
      MSG_WB_DONE:             ev = EV_WB_DONE;
      default:                 ev = EV_OTHER;
    endcase
  end

endmodule

// File: rtl/fwd_disp_ctrl.sv
module fwd_disp_ctrl
  import fwd_disp_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            fire,
  input  fwdEv_e          ev,
  input  logic [ST_W-1:0] lineState,
  output ctrlStb_t        stb,
  output logic [ST_W-1:0] nextState
);

  logic            doSend, doExcl, doWb, doRecycle;
  logic [ST_W-1:0] nxt;
  logic            isHold, isEvict;

  assign isHold  = (lineState == ST_MOD_HOLD) || (lineState == ST_MODX_HOLD);
  assign isEvict = (lineState == ST_MOD_EVICT) || (lineState == ST_SHR_EVICT) ||
                   (lineState == ST_OWN_EVICT);

  always_comb begin
    doSend    = 1'b0;
    doExcl    = 1'b0;
    doWb      = 1'b0;
    doRecycle = 1'b0;
    nxt       = lineState;
    if (isHold && (ev != EV_WB_DONE) && (ev != EV_OTHER)) begin
      doRecycle = 1'b1;
    end else begin
      case (ev)
        EV_FWD_SHARED: begin
          case (lineState)
            ST_SHARED, ST_OWNED, ST_SHR_UP, ST_OWN_UP: doSend = 1'b1;
            ST_MODIFIED, ST_MODX: begin
              doSend = 1'b1;
              nxt    = ST_OWNED;
            end
            ST_MOD_EVICT: begin
              doSend = 1'b1;
              doWb   = 1'b1;
              nxt    = ST_OWN_EVICT;
            end
            ST_SHR_EVICT, ST_OWN_EVICT: begin
              doSend = 1'b1;
              doWb   = 1'b1;
            end
            default: ;
          endcase
        end
        EV_FWD_DMA: begin
          case (lineState)
            ST_SHARED, ST_OWNED, ST_SHR_UP, ST_OWN_UP,
            ST_MODIFIED, ST_MODX: doSend = 1'b1;
            ST_MOD_EVICT, ST_SHR_EVICT, ST_OWN_EVICT: begin
              doSend = 1'b1;
              doWb   = 1'b1;
            end
            default: ;
          endcase
        end
        EV_FWD_EXCL: begin
          case (lineState)
            ST_MODIFIED, ST_MODX, ST_OWNED: begin
              doSend = 1'b1;
              doExcl = 1'b1;
              nxt    = ST_INVALID;
            end
            ST_OWN_UP: begin
              doSend = 1'b1;
              doExcl = 1'b1;
              nxt    = ST_INV_UP;
            end
            ST_MOD_EVICT, ST_OWN_EVICT: begin
              doSend = 1'b1;
              doExcl = 1'b1;
              doWb   = 1'b1;
              nxt    = ST_DROPPED;
            end
            default: ;
          endcase
        end
        EV_INVAL: begin
          if (lineState == ST_SHARED)      nxt = ST_INVALID;
          else if (lineState == ST_SHR_UP) nxt = ST_INV_UP;
        end
        EV_WB_DONE: begin
          if (isEvict || (lineState == ST_DROPPED)) nxt = ST_INVALID;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    stb.send    = fire & doSend;
    stb.excl    = doExcl;
    stb.fromWb  = doWb;
    stb.pop     = fire & ~doRecycle;
    stb.requeue = fire & doRecycle;
    stb.stWe    = fire & ~doRecycle;
    nextState   = nxt;
  end

  // R11: a message is either consumed or recycled, never both
  a_r11_pop_or_requeue: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.pop && stb.requeue));

  // R4: hold states put back every forwarded request
  a_r4_hold_recycles: assert property (@(posedge clk) disable iff (!rstN)
    (fire && isHold && (ev == EV_FWD_SHARED || ev == EV_FWD_DMA ||
     ev == EV_FWD_EXCL || ev == EV_OWN_EXCL || ev == EV_INVAL))
    |-> (stb.requeue && !stb.send && !stb.stWe));

  // R2: a DMA read never changes the line state
  a_r2_dma_no_downgrade: assert property (@(posedge clk) disable iff (!rstN)
    (fire && ev == EV_FWD_DMA) |-> (nextState == lineState));

  // R5: buffer-sourced replies come only from eviction states
  a_r5_buffer_only_evicting: assert property (@(posedge clk) disable iff (!rstN)
    (stb.send && stb.fromWb) |-> isEvict);

endmodule

// File: rtl/fwd_disp_datapath.sv
module fwd_disp_datapath
  import fwd_disp_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              respReady,
  input  logic [ID_W-1:0]   reqId,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] arrayData,
  input  logic [DATA_W-1:0] wbData,
  output logic              respValid,
  output logic              respExcl,
  output logic              respFromWb,
  output logic [ID_W-1:0]   respDest,
  output logic [ADDR_W-1:0] respAddr,
  output logic [DATA_W-1:0] respData
);

  logic [DATA_W-1:0] srcData;
  assign srcData = stb.fromWb ? wbData : arrayData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respExcl   <= 1'b0;
      respFromWb <= 1'b0;
      respDest   <= '0;
      respAddr   <= '0;
      respData   <= '0;
    end else if (respReady) begin
      respValid <= stb.send;
      if (stb.send) begin
        respExcl   <= stb.excl;
        respFromWb <= stb.fromWb;
        respDest   <= reqId;
        respAddr   <= reqAddr;
        respData   <= srcData;
      end
    end
  end

  // R11: a stalled reply stays put
  a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    !respReady |=> ($stable(respValid) && $stable(respData) && $stable(respDest)));

  // R11: an accepted send shows up one cycle later
  a_r11_reply_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (respReady && stb.send) |=> respValid);

  // R11: a reply only comes with a consumed message that writes state
  a_r11_send_implies_pop: assert property (@(posedge clk) disable iff (!rstN)
    stb.send |-> (stb.pop && stb.stWe));

  // R4: a recycled message produces no reply
  a_r4_requeue_no_reply: assert property (@(posedge clk) disable iff (!rstN)
    (respReady && stb.requeue) |=> !respValid);

endmodule

// File: rtl/fwd_dispatcher.sv
module fwd_dispatcher
  import fwd_disp_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ID_W-1:0]   myId,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqType,
  input  logic [ID_W-1:0]   reqId,
  input  logic [1:0]        reqMachine,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        lineState,
  input  logic [DATA_W-1:0] arrayData,
  input  logic [DATA_W-1:0] wbData,
  input  logic              respReady,
  output logic              respValid,
  output logic              respExcl,
  output logic              respFromWb,
  output logic [ID_W-1:0]   respDest,
  output logic [ADDR_W-1:0] respAddr,
  output logic [DATA_W-1:0] respData,
  output logic              popFwd,
  output logic              recycleReq,
  output logic              stateWe,
  output logic [3:0]        nextState
);

  fwdEv_e   ev;
  ctrlStb_t stb;
  logic     fire;

  assign reqReady = respReady;
  assign fire     = reqValid & respReady;

  fwd_event_classify #(.ID_W(ID_W)) u_classify (
    .reqType    (reqType),
    .reqId      (reqId),
    .reqMachine (reqMachine),
    .myId       (myId),
    .ev         (ev)
  );

  fwd_disp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fire      (fire),
    .ev        (ev),
    .lineState (lineState),
    .stb       (stb),
    .nextState (nextState)
  );

  fwd_disp_datapath #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .respReady  (respReady),
    .reqId      (reqId),
    .reqAddr    (reqAddr),
    .arrayData  (arrayData),
    .wbData     (wbData),
    .respValid  (respValid),
    .respExcl   (respExcl),
    .respFromWb (respFromWb),
    .respDest   (respDest),
    .respAddr   (respAddr),
    .respData   (respData)
  );

  assign popFwd     = stb.pop;
  assign recycleReq = stb.requeue;
  assign stateWe    = stb.stWe;

endmodule

// File: tb/sim_fwd_dispatcher.sv
module sim_fwd_dispatcher;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  myId = 4'd5;
  logic        reqValid;
  logic        reqReady;
  logic [2:0]  reqType;
  logic [3:0]  reqId;
  logic [1:0]  reqMachine;
  logic [31:0] reqAddr;
  logic [3:0]  lineState;
  logic [31:0] arrayData, wbData;
  logic        respReady;
  logic        respValid, respExcl, respFromWb;
  logic [3:0]  respDest;
  logic [31:0] respAddr, respData;
  logic        popFwd, recycleReq, stateWe;
  logic [3:0]  nextState;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign arrayData = 32'hA000_0000 | reqAddr;
  assign wbData    = 32'hB000_0000 | reqAddr;

  fwd_dispatcher u0 (
    .clk(clk), .rstN(rstN), .myId(myId),
    .reqValid(reqValid), .reqReady(reqReady), .reqType(reqType),
    .reqId(reqId), .reqMachine(reqMachine), .reqAddr(reqAddr),
    .lineState(lineState), .arrayData(arrayData), .wbData(wbData),
    .respReady(respReady), .respValid(respValid), .respExcl(respExcl),
    .respFromWb(respFromWb), .respDest(respDest), .respAddr(respAddr),
    .respData(respData), .popFwd(popFwd), .recycleReq(recycleReq),
    .stateWe(stateWe), .nextState(nextState)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // Drive one message, check queue/state outputs before the edge, reply after it.
  task automatic apply(input string tag, input logic [2:0] ty, input logic [3:0] idv,
                       input logic [1:0] mach, input logic [3:0] st, input bit eRec,
                       input logic [3:0] eNext, input bit eSend, input bit eExcl,
                       input bit eWb);
    logic [31:0] a;
    @(negedge clk);
    a          = reqAddr + 32'h40;
    reqAddr    = a;
    reqType    = ty;
    reqId      = idv;
    reqMachine = mach;
    lineState  = st;
    reqValid   = 1'b1;
    #2;
    chk({tag, " reqReady"}, {31'd0, reqReady}, 32'd1);
    chk({tag, " pop"}, {31'd0, popFwd}, {31'd0, !eRec});
    chk({tag, " recycle"}, {31'd0, recycleReq}, {31'd0, eRec});
    chk({tag, " stateWe"}, {31'd0, stateWe}, {31'd0, !eRec});
    if (!eRec) chk({tag, " nextState"}, {28'd0, nextState}, {28'd0, eNext});
    @(posedge clk);
    #2;
    reqValid = 1'b0;
    chk({tag, " respValid"}, {31'd0, respValid}, {31'd0, eSend});
    if (eSend) begin
      chk({tag, " respExcl"}, {31'd0, respExcl}, {31'd0, eExcl});
      chk({tag, " respFromWb"}, {31'd0, respFromWb}, {31'd0, eWb});
      chk({tag, " respData"}, respData, eWb ? (32'hB000_0000 | a) : (32'hA000_0000 | a));
      chk({tag, " respDest"}, {28'd0, respDest}, {28'd0, idv});
      chk({tag, " respAddr"}, respAddr, a);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0; reqValid = 1'b0; respReady = 1'b1;
    reqType = 3'd0; reqId = 4'd0; reqMachine = 2'd0; reqAddr = 32'h0; lineState = 4'd0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 reset respValid", {31'd0, respValid}, 32'd0);
    chk("R11 reset pop", {31'd0, popFwd}, 32'd0);
    chk("R11 reset recycle", {31'd0, recycleReq}, 32'd0);
    chk("R11 reset reqReady", {31'd0, reqReady}, 32'd1);
  endtask

  task automatic t_classify();
    // R1: self request in MODIFIED is consumed silently
    apply("R1 own excl", 3'd0, 4'd5, 2'd0, 4'd3, 0, 4'd3, 0, 0, 0);
    apply("R1 own dmawr", 3'd3, 4'd5, 2'd0, 4'd3, 0, 4'd3, 0, 0, 0);
    // R1: same ID, other kind -> foreign exclusive
    apply("R1 same id l2", 3'd0, 4'd5, 2'd1, 4'd3, 0, 4'd0, 1, 1, 0);
    apply("R1 dmawr foreign", 3'd3, 4'd9, 2'd3, 4'd4, 0, 4'd0, 1, 1, 0);
  endtask

  task automatic t_mod_reads();
    apply("R2 dma in M", 3'd2, 4'd9, 2'd3, 4'd3, 0, 4'd3, 1, 0, 0);
    apply("R2 dma in MX", 3'd2, 4'd9, 2'd3, 4'd4, 0, 4'd4, 1, 0, 0);
    apply("R2 gets in M", 3'd1, 4'd9, 2'd0, 4'd3, 0, 4'd2, 1, 0, 0);
    apply("R2 gets in MX", 3'd1, 4'd9, 2'd0, 4'd4, 0, 4'd2, 1, 0, 0);
  endtask

  task automatic t_pass_through();
    for (int s = 1; s <= 6; s++) begin
      if (s == 3 || s == 4) continue;
      apply("R3 gets", 3'd1, 4'd7, 2'd0, s[3:0], 0, s[3:0], 1, 0, 0);
      apply("R3 dma", 3'd2, 4'd7, 2'd3, s[3:0], 0, s[3:0], 1, 0, 0);
    end
  endtask

  task automatic t_hold_recycle();
    for (int s = 8; s <= 9; s++) begin
      apply("R4 gets", 3'd1, 4'd9, 2'd0, s[3:0], 1, s[3:0], 0, 0, 0);
      apply("R4 dma", 3'd2, 4'd9, 2'd3, s[3:0], 1, s[3:0], 0, 0, 0);
      apply("R4 fwd excl", 3'd0, 4'd9, 2'd0, s[3:0], 1, s[3:0], 0, 0, 0);
      apply("R4 own excl", 3'd0, 4'd5, 2'd0, s[3:0], 1, s[3:0], 0, 0, 0);
      apply("R4 inval", 3'd4, 4'd2, 2'd2, s[3:0], 1, s[3:0], 0, 0, 0);
    end
  endtask

  task automatic t_mod_evict();
    apply("R5 dma in MEV", 3'd2, 4'd9, 2'd3, 4'd10, 0, 4'd10, 1, 0, 1);
    apply("R5 getx in MEV", 3'd0, 4'd9, 2'd0, 4'd10, 0, 4'd13, 1, 1, 1);
    apply("R5 gets in MEV", 3'd1, 4'd9, 2'd0, 4'd10, 0, 4'd12, 1, 0, 1);
  endtask

  task automatic t_shr_own_evict();
    apply("R6 gets in SEV", 3'd1, 4'd9, 2'd0, 4'd11, 0, 4'd11, 1, 0, 1);
    apply("R6 dma in SEV", 3'd2, 4'd9, 2'd3, 4'd11, 0, 4'd11, 1, 0, 1);
    apply("R6 gets in OEV", 3'd1, 4'd9, 2'd0, 4'd12, 0, 4'd12, 1, 0, 1);
    apply("R6 dma in OEV", 3'd2, 4'd9, 2'd3, 4'd12, 0, 4'd12, 1, 0, 1);
    apply("R6 getx in OEV", 3'd0, 4'd9, 2'd0, 4'd12, 0, 4'd13, 1, 1, 1);
  endtask

  task automatic t_excl_transfer();
    apply("R7 getx in M", 3'd0, 4'd9, 2'd0, 4'd3, 0, 4'd0, 1, 1, 0);
    apply("R7 getx in MX", 3'd0, 4'd9, 2'd0, 4'd4, 0, 4'd0, 1, 1, 0);
    apply("R7 getx in O", 3'd0, 4'd9, 2'd0, 4'd2, 0, 4'd0, 1, 1, 0);
    apply("R7 getx in OU", 3'd0, 4'd9, 2'd0, 4'd6, 0, 4'd7, 1, 1, 0);
  endtask

  task automatic t_inval();
    apply("R8 inv in S", 3'd4, 4'd2, 2'd2, 4'd1, 0, 4'd0, 0, 0, 0);
    apply("R8 inv in SU", 3'd4, 4'd2, 2'd2, 4'd5, 0, 4'd7, 0, 0, 0);
  endtask

  task automatic t_wback();
    apply("R9 wb in MEV", 3'd5, 4'd2, 2'd2, 4'd10, 0, 4'd0, 0, 0, 0);
    apply("R9 wb in SEV", 3'd5, 4'd2, 2'd2, 4'd11, 0, 4'd0, 0, 0, 0);
    apply("R9 wb in OEV", 3'd5, 4'd2, 2'd2, 4'd12, 0, 4'd0, 0, 0, 0);
    apply("R9 wb in DROP", 3'd5, 4'd2, 2'd2, 4'd13, 0, 4'd0, 0, 0, 0);
    apply("R9 wb in M", 3'd5, 4'd2, 2'd2, 4'd3, 0, 4'd3, 0, 0, 0);
    apply("R9 wb in HOLD", 3'd5, 4'd2, 2'd2, 4'd8, 0, 4'd8, 0, 0, 0);
  endtask

  task automatic t_default();
    apply("R10 type6", 3'd6, 4'd9, 2'd0, 4'd3, 0, 4'd3, 0, 0, 0);
    apply("R10 type7", 3'd7, 4'd9, 2'd0, 4'd11, 0, 4'd11, 0, 0, 0);
    apply("R10 gets in I", 3'd1, 4'd9, 2'd0, 4'd0, 0, 4'd0, 0, 0, 0);
    apply("R10 getx in S", 3'd0, 4'd9, 2'd0, 4'd1, 0, 4'd1, 0, 0, 0);
    apply("R10 inv in M", 3'd4, 4'd2, 2'd2, 4'd3, 0, 4'd3, 0, 0, 0);
  endtask

  task automatic t_stall();
    logic [31:0] held;
    apply("R11 pre-stall", 3'd1, 4'd9, 2'd0, 4'd1, 0, 4'd1, 1, 0, 0);
    held = respData;
    @(negedge clk);
    respReady  = 1'b0;
    reqAddr    = reqAddr + 32'h40;
    reqType    = 3'd0;
    reqId      = 4'd9;
    reqMachine = 2'd0;
    lineState  = 4'd3;
    reqValid   = 1'b1;
    #2;
    chk("R11 stall reqReady", {31'd0, reqReady}, 32'd0);
    chk("R11 stall pop", {31'd0, popFwd}, 32'd0);
    chk("R11 stall recycle", {31'd0, recycleReq}, 32'd0);
    chk("R11 stall stateWe", {31'd0, stateWe}, 32'd0);
    @(posedge clk);
    #2;
    chk("R11 stall respValid held", {31'd0, respValid}, 32'd1);
    chk("R11 stall respData held", respData, held);
    chk("R11 stall respExcl held", {31'd0, respExcl}, 32'd0);
    @(negedge clk);
    respReady = 1'b1;
    #2;
    chk("R11 resume pop", {31'd0, popFwd}, 32'd1);
    @(posedge clk);
    #2;
    reqValid = 1'b0;
    chk("R11 resume respExcl", {31'd0, respExcl}, 32'd1);
    chk("R11 resume respData", respData, 32'hA000_0000 | reqAddr);
    @(posedge clk);
    #2;
    chk("R11 idle respValid", {31'd0, respValid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_classify();
    t_mod_reads();
    t_pass_through();
    t_hold_recycle();
    t_mod_evict();
    t_shr_own_evict();
    t_excl_transfer();
    t_inval();
    t_wback();
    t_default();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule